// File: doc/BRIEF.md
# Bit Scan and Bit Test Unit

This unit performs two families of single-operand bit operations on a 16-bit or 32-bit word. The scan family locates a set bit, either the lowest one (searching upward from bit 0) or the highest one (searching downward from the top bit of the selected width), and returns its position. The test family reads one selected bit into a carry flag and can leave the word unchanged, force the bit to one, force it to zero, or invert it.

A request is presented on `op_valid` with an operation code, a width select, a source word and a bit index. The result word and the two flags are registered and appear one clock after the request. A scan updates only the zero flag. When the scanned word has no set bit, the result word keeps its old value. A test updates only the carry flag. The unit has no byte-width mode: the width select chooses between 16 and 32 bits.

Top module: `bsbt_unit`

## Requirements
- R1: Forward scan (op code 3'b000) writes the position of the lowest set bit of the operand to `result` and clears `zero_flag`; for operand 0x88 the result is 3.
- R2: Reverse scan (op code 3'b001) writes the position of the highest set bit of the operand to `result` and clears `zero_flag`; for operand 0x88 the result is 7.
- R3: A scan of an operand with no set bit sets `zero_flag` and leaves `result` at its previous value.
- R4: With `wide_sel` = 0 the operand is `src_word[15:0]` only: bits 31:16 are ignored by scans and tests, and a test writes zeros to `result[31:16]`. With `wide_sel` = 1 all 32 bits are used.
- R5: Every test operation (op codes 3'b100, 3'b101, 3'b110, 3'b111) copies the original value of the selected bit into `carry_flag`.
- R6: Plain test (3'b100) writes the operand to `result` unchanged.
- R7: Test-and-set (3'b101) writes the operand with the selected bit forced to 1. Test-and-reset (3'b110) writes it with that bit forced to 0. Test-and-complement (3'b111) writes it with that bit inverted.
- R8: The bit index is taken modulo the operand width: its low 4 bits in 16-bit mode and all 5 bits in 32-bit mode.
- R9: `zero_flag` changes only on a scan and `carry_flag` changes only on a test. Op codes 3'b010 and 3'b011, and any cycle with `op_valid` low, change no output.
- R10: Outputs change on the clock edge that samples the request. An active-low reset clears `result`, `zero_flag` and `carry_flag` to 0.
- R11: Starting from 0x88 and feeding each result back as the next operand, the steps test 3, set 0, reset 7, complement 1 give carries 1, 0, 1, 0 and a final result of 0x0B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 3 | Operation select |
| wide_sel | input | 1 | 1 selects a 32-bit operand, 0 selects a 16-bit operand |
| src_word | input | 32 | Source operand |
| bit_index | input | 5 | Bit position for the test operations |
| result | output | 32 | Scan position or modified operand |
| zero_flag | output | 1 | Set when the last scan found no set bit |
| carry_flag | output | 1 | Original value of the last tested bit |

## Verification
On every cycle the assertions check that each flag holds unless its own family of operation ran, that a scan of an empty operand sets the zero flag and holds the result, that a test changes at most one bit and reports the prior bit in carry, and that a narrow scan never returns a position of 16 or more. The exact position a scan returns, the direction of priority when several bits are set, the index wrap and the feedback sequence can only be shown by the bench. It sweeps one-bit and two-bit patterns at every position in both widths, with every index, and computes the expected values itself.

// File: rtl/bsbt_pkg.sv
package bsbt_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NARROW_W = 16;
    localparam int unsigned IDX_W    = $clog2(DATA_W);

    typedef enum logic [2:0] {
        OP_SCAN_UP = 3'b000,
        OP_SCAN_DN = 3'b001,
        OP_RSVD_A  = 3'b010,
        OP_RSVD_B  = 3'b011,
        OP_TEST    = 3'b100,
        OP_SET     = 3'b101,
        OP_CLR     = 3'b110,
        OP_FLIP    = 3'b111
    } bsbt_op_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_ONE  = 2'd1,
        ACT_ZERO = 2'd2,
        ACT_INV  = 2'd3
    } bit_act_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              zf;
        logic              cf;
    } bsbt_state_t;

endpackage

// File: rtl/bsbt_scan.sv
module bsbt_scan #(
    parameter int unsigned W    = 32,
    parameter int unsigned IW   = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] low_pos,
    output logic [IW-1:0] high_pos,
    output logic          empty
);

    // lowest set bit: walk downward so the lowest hit is written last
    always_comb begin
        low_pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                low_pos = IW'(i);
            end
        end
    end

    // highest set bit: walk upward so the highest hit is written last
    always_comb begin
        high_pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                high_pos = IW'(i);
            end
        end
    end

    assign empty = (vec == '0);

endmodule

// File: rtl/bsbt_bitop.sv
module bsbt_bitop
    import bsbt_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  operand,
    input  logic [IW-1:0] pos,
    input  bit_act_e      action,
    output logic [W-1:0]  updated,
    output logic          prior
);

    logic [W-1:0] sel_mask;

    assign sel_mask = W'(1) << pos;
    assign prior    = |(operand & sel_mask);

    always_comb begin
        unique case (action)
            ACT_ONE:  updated = operand | sel_mask;
            ACT_ZERO: updated = operand & ~sel_mask;
            ACT_INV:  updated = operand ^ sel_mask;
            default:  updated = operand;
        endcase
    end

endmodule

// File: rtl/bsbt_unit.sv
module bsbt_unit
    import bsbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic              wide_sel,
    input  logic [DATA_W-1:0] src_word,
    input  logic [IDX_W-1:0]  bit_index,
    output logic [DATA_W-1:0] result,
    output logic              zero_flag,
    output logic              carry_flag
);

    localparam int unsigned NARROW_IW = $clog2(NARROW_W);
    localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    bsbt_state_t state_d, state_q;

    logic [DATA_W-1:0] src_masked;
    logic [IDX_W-1:0]  eff_pos;
    logic [IDX_W-1:0]  low_pos, high_pos;
    logic              empty;
    logic [DATA_W-1:0] updated;
    logic              prior;
    bit_act_e          action;
    bsbt_op_e          op;

    assign op = bsbt_op_e'(op_code);

    // operand width selection and index wrap
    generate
        if (NARROW_W < DATA_W) begin : g_narrow
            assign src_masked = wide_sel ? src_word : (src_word & NARROW_MASK);
            assign eff_pos    = wide_sel ? bit_index
                                         : {{(IDX_W-NARROW_IW){1'b0}}, bit_index[NARROW_IW-1:0]};
        end else begin : g_single
            assign src_masked = src_word;
            assign eff_pos    = bit_index;
        end
    endgenerate

    assign action = bit_act_e'(op_code[1:0]);

    bsbt_scan #(.W(DATA_W), .IW(IDX_W)) i_scan (
        .vec      (src_masked),
        .low_pos  (low_pos),
        .high_pos (high_pos),
        .empty    (empty)
    );

    bsbt_bitop #(.W(DATA_W), .IW(IDX_W)) i_bitop (
        .operand (src_masked),
        .pos     (eff_pos),
        .action  (action),
        .updated (updated),
        .prior   (prior)
    );

    always_comb begin
        state_d = state_q;
        if (op_valid) begin
            unique case (op)
                OP_SCAN_UP: begin
                    state_d.zf = empty;
                    if (!empty) state_d.res = DATA_W'(low_pos);
                end
                OP_SCAN_DN: begin
                    state_d.zf = empty;
                    if (!empty) state_d.res = DATA_W'(high_pos);
                end
                OP_TEST, OP_SET, OP_CLR, OP_FLIP: begin
                    state_d.cf  = prior;
                    state_d.res = updated;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result     = state_q.res;
    assign zero_flag  = state_q.zf;
    assign carry_flag = state_q.cf;

    // checks
    logic is_scan, is_test;
    assign is_scan = op_valid && (op_code[2:1] == 2'b00);
    assign is_test = op_valid && op_code[2];

    AST_EMPTY_SCAN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_scan && src_masked == '0) |=> (zero_flag && $stable(result))); // R3

    AST_CF_ONLY_ON_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        !is_test |=> $stable(carry_flag)); // R9

    AST_ZF_ONLY_ON_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        !is_scan |=> $stable(zero_flag)); // R9

    AST_TEST_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        is_test |=> ($countones(result ^ $past(src_masked)) <= 1)); // R7

    AST_TEST_PRIOR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        is_test |=> (carry_flag == $past(src_word[eff_pos]))); // R5

    AST_NARROW_SCAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_scan && !wide_sel && src_masked != '0) |=> (result < NARROW_W)); // R4

endmodule

// File: tb/test_bsbt_unit.sv
module test_bsbt_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'b000;
    logic        wide_sel = 1'b1;
    logic [31:0] src_word = '0;
    logic [4:0]  bit_index = '0;
    logic [31:0] result;
    logic        zero_flag;
    logic        carry_flag;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] exp_res = '0;
    logic        exp_zf  = 1'b0;
    logic        exp_cf  = 1'b0;

    always #5 clk = ~clk;

    bsbt_unit i_bsbt_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .wide_sel   (wide_sel),
        .src_word   (src_word),
        .bit_index  (bit_index),
        .result     (result),
        .zero_flag  (zero_flag),
        .carry_flag (carry_flag)
    );

    task automatic check(input string req);
        n_checks++;
        if (result !== exp_res || zero_flag !== exp_zf || carry_flag !== exp_cf) begin
            n_fail++;
            $display("FAIL %s: got res=%h zf=%b cf=%b expected res=%h zf=%b cf=%b",
                     req, result, zero_flag, carry_flag, exp_res, exp_zf, exp_cf);
        end
    endtask

    // expected value from the requirements, then apply and compare
    task automatic run_op(input logic vld, input logic [2:0] op, input logic wide,
                          input logic [31:0] src, input logic [4:0] idx, input string req);
        logic [31:0] m;
        int w, k, pos;
        w = wide ? 32 : 16;
        m = wide ? src : (src % 32'h10000);
        if (vld) begin
            if (op == 3'b000 || op == 3'b001) begin
                if (m == 0) exp_zf = 1'b1;
                else begin
                    exp_zf = 1'b0;
                    pos = -1;
                    for (int b = 0; b < w; b++) begin
                        if (m[b] && (op == 3'b001 || pos < 0)) pos = b;
                    end
                    exp_res = 32'(pos);
                end
            end else if (op[2]) begin
                k = int'(idx) % w;
                exp_cf = m[k];
                exp_res = m;
                case (op)
                    3'b101: exp_res[k] = 1'b1;
                    3'b110: exp_res[k] = 1'b0;
                    3'b111: exp_res[k] = ~m[k];
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        op_valid  = vld;
        op_code   = op;
        wide_sel  = wide;
        src_word  = src;
        bit_index = idx;
        @(posedge clk);
        #1;
        check(req);
        op_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset");
        rst_n = 1'b1;

        // R1 R2 examples
        run_op(1'b1, 3'b000, 1'b1, 32'h88, 5'd0, "R1 fwd 0x88");
        run_op(1'b1, 3'b001, 1'b1, 32'h88, 5'd0, "R2 rev 0x88");

        // R3 zero operand holds result
        run_op(1'b1, 3'b000, 1'b1, 32'h0, 5'd0, "R3 fwd zero");
        run_op(1'b1, 3'b001, 1'b0, 32'hFFFF_0000, 5'd0, "R3 R4 rev narrow zero");

        // R1 R2 R4 sweep of one- and two-bit patterns in both widths
        for (int wd = 0; wd < 2; wd++) begin
            for (int i = 0; i < 32; i++) begin
                for (int j = 0; j < 32; j += 3) begin
                    v = (32'h1 << i) | (32'h1 << j);
                    run_op(1'b1, 3'b000, wd[0], v, 5'd0, "R1 R4 fwd sweep");
                    run_op(1'b1, 3'b001, wd[0], v, 5'd0, "R2 R4 rev sweep");
                end
            end
        end

        // R5 R6 R7 R8 every op, every index, both widths, several patterns
        for (int wd = 0; wd < 2; wd++) begin
            for (int p = 0; p < 4; p++) begin
                v = (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FFFF :
                    (p == 2) ? 32'hA5C3_1E78 : 32'h5A3C_E187;
                for (int op = 4; op < 8; op++) begin
                    for (int x = 0; x < 32; x++) begin
                        run_op(1'b1, 3'(op), wd[0], v, 5'(x), "R5 R6 R7 R8 test sweep");
                    end
                end
            end
        end

        // R9 reserved codes and idle cycles change nothing
        run_op(1'b1, 3'b101, 1'b1, 32'h0, 5'd9, "R7 set for R9 setup");
        run_op(1'b1, 3'b000, 1'b1, 32'h0, 5'd0, "R3 zf set for R9 setup");
        run_op(1'b1, 3'b010, 1'b1, 32'hFFFF_FFFF, 5'd4, "R9 reserved 010");
        run_op(1'b1, 3'b011, 1'b0, 32'h1234_5678, 5'd2, "R9 reserved 011");
        run_op(1'b0, 3'b111, 1'b1, 32'hFFFF_FFFF, 5'd9, "R9 idle test");
        run_op(1'b0, 3'b000, 1'b1, 32'h10, 5'd0, "R9 idle scan");
        run_op(1'b1, 3'b100, 1'b1, 32'h1, 5'd0, "R9 test keeps zf");
        run_op(1'b1, 3'b001, 1'b1, 32'h8000_0000, 5'd0, "R9 scan keeps cf");

        // R11 feedback sequence
        run_op(1'b1, 3'b100, 1'b1, 32'h88, 5'd3, "R11 step test 3");
        if (carry_flag !== 1'b1 || result !== 32'h88) $display("FAIL R11: got cf=%b res=%h expected cf=1 res=00000088", carry_flag, result);
        n_checks++; if (carry_flag !== 1'b1 || result !== 32'h88) n_fail++;
        run_op(1'b1, 3'b101, 1'b1, result, 5'd0, "R11 step set 0");
        run_op(1'b1, 3'b110, 1'b1, result, 5'd7, "R11 step reset 7");
        run_op(1'b1, 3'b111, 1'b1, result, 5'd1, "R11 step complement 1");
        n_checks++;
        if (result !== 32'h0B || carry_flag !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: got res=%h cf=%b expected res=0000000b cf=0", result, carry_flag);
        end

        // R10 reset clears again
        @(negedge clk);
        rst_n = 1'b0;
        exp_res = '0; exp_zf = 1'b0; exp_cf = 1'b0;
        #1;
        check("R10 second reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule